// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a compact serial test port for a memory device, built on IEEE 1149.1. It takes the test clock, the mode-select line, serial data in and an asynchronous power-on reset. It returns serial data out with a separate output enable, so the pad logic can place the pin in high impedance. The port contains the sixteen-state controller, a three-bit instruction register with a separate active stage, a one-bit bypass stage, a 32-bit fixed identification value and a boundary chain of parameterised length. The boundary chain's parallel load inputs and its latched outputs are brought out as ports.

A board tester moves the controller by clocking mode-select values. It loads an instruction through the instruction path and then captures, shifts and updates whichever data register that instruction selects. Mode-select and data-in are sampled on the rising test clock edge. Serial data out is re-registered on the falling edge, which gives the next device in the chain half a cycle of setup.

Top module: `scan_port`

## Requirements
- R1: `tms` and `tdi` are sampled only on the rising edge of `tck`. `tdo` and `tdo_oe` change only on the falling edge of `tck`, so across a rising edge they hold their value.
- R2: Holding `tms` at 1 for five rising `tck` edges in a row brings the controller to Test-Logic-Reset from any state. Driving `rst_n` low does the same at once, without a clock.
- R3: `tdo_oe` is 0 after reset. It is 1 exactly while the controller is in Shift-IR or Shift-DR, taking effect from the falling edge that follows entry into that state.
- R4: The active instruction is 3 bits wide. Reset and Test-Logic-Reset set it to the identification instruction (code 001), so a data scan that follows reset returns the identification value.
- R5: Capture-IR loads the instruction shift stage with 001: the two low bits get the pattern 01 and the top bit gets 0. The first three bits shifted out are therefore 1, 0, 0.
- R6: A shifted-in instruction becomes active only on the rising edge taken in Update-IR. Until then, the previous instruction keeps choosing the data path.
- R7: Each scan register takes `tdi` into its most significant bit and presents its least significant bit on `tdo`. Exactly one register is in the path: the instruction stage (3 bits) in the IR column, and in the DR column the bypass (1), identification (32) or boundary (`RING_W`) register, as the active instruction selects.
- R8: With the bypass path selected, Capture-DR loads the bypass bit with 0.
- R9: With the identification instruction active, Capture-DR loads `ID_VALUE`, whose bit 0 must be 1, and Shift-DR shifts it out least significant bit first.
- R10: With a boundary instruction active, Capture-DR loads the boundary chain from `ring_in`, and Update-DR copies the chain to `ring_out`. Under any other instruction, `ring_out` keeps its value. `ring_out` is 0 after reset.
- R11: The instruction codes are: 000 external test, 001 identification, 010 sample with outputs high-Z, 100 sample/preload, 111 bypass. The reserved codes 011, 101 and 110 select the bypass path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, registered on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; 0 means high impedance |
| ring_in | input | RING_W | Parallel values captured into the boundary chain |
| ring_out | output | RING_W | Latched boundary values written in Update-DR |

## Verification
The bench sets the boundary chain to `RING_W` = 6 and the identification value to 32'h2B9D4C17. With a short chain, one 40-bit data scan shows the whole captured ring, then the tail of the serial input coming out after it. The same scan length also passes the full 32-bit identification value plus a tail, so all eight instruction codes can share one scan routine. The odd identification value exercises the required bit-0 rule. The distinct bit patterns in `ring_in` and in the shifted data make an off-by-one in length or ordering show up as a mismatch.

// File: rtl/scan_port_pkg.sv
// Package: shared controller state type, instruction codes and the
// data path selector for the boundary scan test port.
// Assumes: a three-bit instruction register.
package scan_port_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET,   ST_IDLE,
        ST_SEL_DR,  ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR,  ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_RING
    } dr_path_e;

    // Maps an instruction to the data register it selects; reserved codes bypass.
    function automatic dr_path_e decode_op(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: decode_op = PATH_RING;
            OP_IDENT:                         decode_op = PATH_IDENT;
            default:                          decode_op = PATH_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/scan_port_ctrl.sv
// Module: sixteen-state test port controller.
// Walks the standard state graph on rising tck, steered by tms.
// Assumes: rst_n is asynchronous and puts the controller in ST_RESET.
module scan_port_ctrl
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next state from the current state and tms.
    always_comb begin
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with asynchronous power-on reset.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

endmodule

// File: rtl/scan_port_ir.sv
// Module: instruction register with a shift stage and an active stage.
// The shift stage captures 001 and shifts LSB first. The active stage
// changes only in Update-IR, or falls back to the identification code in reset.
// Assumes: the strobes are one-hot decodes of the controller state.
module scan_port_ir
    import scan_port_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_active,
    output dr_path_e        path
);

    // Shift stage: capture the fixed pattern, or shift tdi in at the MSB.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)     ir_shift <= IR_CAPTURE;
        else if (cap_ir) ir_shift <= IR_CAPTURE;
        else if (sh_ir)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // Active stage: identification after reset, new code on update.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)       ir_active <= OP_IDENT;
        else if (in_reset) ir_active <= OP_IDENT;
        else if (upd_ir)   ir_active <= ir_shift;
    end

    // Data path selected by the active instruction.
    always_comb path = decode_op(ir_active);

endmodule

// File: rtl/scan_port_dr.sv
// Module: data registers: the bypass bit, the identification shifter
// and the boundary chain with its update latch. Only the register that
// the path selects captures, shifts or updates.
// Assumes: ID_VALUE bit 0 is 1; RING_W >= 1.
module scan_port_dr
    import scan_port_pkg::*;
#(
    parameter int          RING_W   = 16,
    parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              cap_dr,
    input  logic              sh_dr,
    input  logic              upd_dr,
    input  dr_path_e          path,
    input  logic [RING_W-1:0] ring_in,
    output logic [RING_W-1:0] ring_out,
    output logic              byp_bit,
    output logic              dr_lsb
);

    localparam int ID_W = 32;

    logic [ID_W-1:0]   id_sh;
    logic [RING_W-1:0] ring_sh;

    if (ID_VALUE[0] != 1'b1) begin : g_bad_id
        $error("ID_VALUE bit 0 must be 1");
    end

    // Bypass bit: cleared on capture, otherwise a one-stage delay.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) byp_bit <= 1'b0;
        else if (path == PATH_BYPASS) begin
            if (cap_dr)     byp_bit <= 1'b0;
            else if (sh_dr) byp_bit <= tdi;
        end
    end

    // Identification shifter: load the fixed value, shift LSB first.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) id_sh <= ID_VALUE;
        else if (path == PATH_IDENT) begin
            if (cap_dr)     id_sh <= ID_VALUE;
            else if (sh_dr) id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    // Boundary chain: capture the ring, shift LSB first.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) ring_sh <= '0;
        else if (path == PATH_RING) begin
            if (cap_dr) ring_sh <= ring_in;
            else if (sh_dr) begin
                if (RING_W == 1) ring_sh[RING_W-1] <= tdi;
                else             ring_sh <= {tdi, ring_sh[RING_W-1:1]};
            end
        end
    end

    // Boundary update latch: written in Update-DR under a boundary instruction.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                          ring_out <= '0;
        else if (upd_dr && path == PATH_RING) ring_out <= ring_sh;
    end

    // Serial output of the selected register.
    always_comb begin
        case (path)
            PATH_IDENT: dr_lsb = id_sh[0];
            PATH_RING:  dr_lsb = ring_sh[0];
            default:    dr_lsb = byp_bit;
        endcase
    end

endmodule

// File: rtl/scan_port.sv
// Module: top of the boundary scan test port. Joins the controller,
// the instruction register and the data registers, and re-times the
// serial output and its enable on the falling edge of tck.
// Assumes: rst_n is an asynchronous power-on reset; pad drivers sit outside.
module scan_port
    import scan_port_pkg::*;
#(
    parameter int          RING_W   = 16,
    parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic [RING_W-1:0] ring_in,
    output logic [RING_W-1:0] ring_out
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] ir_active;
    dr_path_e        path;
    logic            bypass_bit;
    logic            dr_lsb;

    scan_port_ctrl u_ctrl (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    scan_port_ir u_ir (
        .tck       (tck),
        .rst_n     (rst_n),
        .tdi       (tdi),
        .in_reset  (state == ST_RESET),
        .cap_ir    (state == ST_CAP_IR),
        .sh_ir     (state == ST_SH_IR),
        .upd_ir    (state == ST_UPD_IR),
        .ir_shift  (ir_shift),
        .ir_active (ir_active),
        .path      (path)
    );

    scan_port_dr #(
        .RING_W   (RING_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .cap_dr   (state == ST_CAP_DR),
        .sh_dr    (state == ST_SH_DR),
        .upd_dr   (state == ST_UPD_DR),
        .path     (path),
        .ring_in  (ring_in),
        .ring_out (ring_out),
        .byp_bit  (bypass_bit),
        .dr_lsb   (dr_lsb)
    );

    // Falling-edge output stage: enable in the shift states, present the selected LSB.
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
            if (state == ST_SH_IR)      tdo <= ir_shift[0];
            else if (state == ST_SH_DR) tdo <= dr_lsb;
            else                        tdo <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_port_chk.sv
// Module: assertion checker bound to scan_port. It watches the controller
// state, the instruction stages, the bypass bit and the output enable.
// Assumes: the bind below connects the internal nets of the top module.
module scan_port_chk
    import scan_port_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_shift,
    input logic [IR_W-1:0] ir_active,
    input dr_path_e        path,
    input logic            bypass_bit,
    input logic            tdo_oe
);

    // R2: five rising edges with tms high end in reset.
    p_five_tms_reset_r2: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> state == ST_RESET);

    // R3: the enable seen at a rising edge matches the state held since the last falling edge.
    p_oe_in_shift_r3: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

    // R4: the reset state restores the identification instruction.
    p_reset_ident_r4: assert property (@(posedge tck) disable iff (!rst_n)
        state == ST_RESET |=> ir_active == OP_IDENT);

    // R5: Capture-IR leaves 01 in the two low bits.
    p_capture_ir_r5: assert property (@(posedge tck) disable iff (!rst_n)
        state == ST_CAP_IR |=> ir_shift[1:0] == 2'b01);

    // R6: outside Update-IR and reset the active instruction holds.
    p_ir_hold_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_active));

    // R8: capture under the bypass path clears the bypass bit.
    p_bypass_zero_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && path == PATH_BYPASS) |=> !bypass_bit);

endmodule

bind scan_port scan_port_chk u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .tms        (tms),
    .state      (state),
    .ir_shift   (ir_shift),
    .ir_active  (ir_active),
    .path       (path),
    .bypass_bit (bypass_bit),
    .tdo_oe     (tdo_oe)
);

// File: tb/scan_port_tb.sv
// Bench for scan_port: a vector table over all eight instruction codes,
// then directed tests for reset, the five-tms escape, pause/re-entry
// and boundary update.
module scan_port_tb;

    localparam int          RING_W = 6;
    localparam logic [31:0] ID_VAL = 32'h2B9D_4C17;
    localparam int          DR_N   = 40;

    logic              tck = 1'b0;
    logic              rst_n = 1'b0;
    logic              tms = 1'b1;
    logic              tdi = 1'b0;
    logic              tdo;
    logic              tdo_oe;
    logic [RING_W-1:0] ring_in = '0;
    logic [RING_W-1:0] ring_out;

    int n_checks = 0;
    int n_errors = 0;
    int r1_bad   = 0;
    int r3_bad   = 0;

    always #5 tck = ~tck;

    scan_port #(.RING_W(RING_W), .ID_VALUE(ID_VAL)) u_dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .ring_in(ring_in), .ring_out(ring_out)
    );

    // Vector table entry: {instruction code, expected path: 0 ring, 1 ident, 2 bypass}.
    localparam logic [4:0] VEC [8] = '{
        {3'b000, 2'd0}, {3'b001, 2'd1}, {3'b010, 2'd0}, {3'b011, 2'd2},
        {3'b100, 2'd0}, {3'b101, 2'd2}, {3'b110, 2'd2}, {3'b111, 2'd2}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: sample tdo after the falling edge, drive inputs, take the rising edge.
    task automatic tick(input logic m, input logic d, output logic so, output logic oe);
        @(negedge tck); #1;
        so = tdo; oe = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck); #1;
        if (tdo !== so || tdo_oe !== oe) r1_bad++;
    endtask

    task automatic step(input logic m);
        logic so, oe;
        tick(m, 1'b0, so, oe);
    endtask

    // Full scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic scan(input logic is_ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout);
        logic so, oe;
        dout = '0;
        step(1'b1);
        if (is_ir) step(1'b1);
        step(1'b0);
        tick(1'b0, 1'b0, so, oe);
        if (oe) r3_bad++;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], so, oe);
            dout[i] = so;
            if (!oe) r3_bad++;
        end
        tick(1'b1, 1'b0, so, oe);
        if (oe) r3_bad++;
        step(1'b0);
    endtask

    function automatic logic [63:0] expect_out(input int len, input logic [63:0] cap,
                                               input logic [63:0] din);
        logic [63:0] e = '0;
        for (int i = 0; i < DR_N; i++) e[i] = (i < len) ? cap[i] : din[i - len];
        return e;
    endfunction

    initial begin
        logic [63:0] dout, din, exp;
        logic [RING_W-1:0] prev_out;
        logic so, oe;

        // Reset state (R3, R10).
        #2;
        check("R3 oe low in reset", {63'd0, tdo_oe}, 64'd0);
        check("R10 ring_out zero in reset", {58'd0, ring_out}, 64'd0);
        #20 rst_n = 1'b1;
        step(1'b0);

        // R4, R9: without any IR load the identification value comes out.
        din = 64'h0000_00A5_5A5A_5A5A;
        scan(1'b0, DR_N, din, dout);
        check("R4 R9 ident after reset", dout[DR_N-1:0], expect_out(32, {32'd0, ID_VAL}, din));

        // Vector loop over all codes (R5, R6, R7, R8, R9, R10, R11).
        for (int v = 0; v < 8; v++) begin
            logic [2:0] code = VEC[v][4:2];
            logic [1:0] kind = VEC[v][1:0];
            int len;
            logic [63:0] cap;
            ring_in = 6'b101101 ^ {3'b000, code};
            prev_out = ring_out;
            scan(1'b1, 3, {61'd0, code}, dout);
            check("R5 capture-IR pattern", dout[2:0], 64'd1);
            din = 64'hC3A5_96E1_7B2D_4F08 ^ {61'd0, code} ^ (64'd1 << (8 + v));
            scan(1'b0, DR_N, din, dout);
            case (kind)
                2'd0:    begin len = RING_W; cap = {58'd0, ring_in}; end
                2'd1:    begin len = 32;     cap = {32'd0, ID_VAL}; end
                default: begin len = 1;      cap = 64'd0; end
            endcase
            exp = expect_out(len, cap, din);
            if (kind == 2'd0)      check("R10 R11 R7 R6 ring path", dout[DR_N-1:0], exp);
            else if (kind == 2'd1) check("R9 R11 R6 ident path", dout[DR_N-1:0], exp);
            else                   check("R8 R11 R7 bypass path", dout[DR_N-1:0], exp);
            if (kind == 2'd0) check("R10 update copies chain", {58'd0, ring_out},
                                    {58'd0, din[DR_N-1 -: RING_W]});
            else              check("R10 update ignored", {58'd0, ring_out}, {58'd0, prev_out});
        end

        // R2: five tms high from inside Shift-DR under bypass.
        scan(1'b1, 3, 64'd7, dout);
        step(1'b1); step(1'b0); step(1'b0);
        for (int k = 0; k < 5; k++) step(1'b1);
        step(1'b0);
        din = 64'h0000_0033_1234_5678;
        scan(1'b0, DR_N, din, dout);
        check("R2 R4 five-tms reset restores ident", dout[DR_N-1:0],
              expect_out(32, {32'd0, ID_VAL}, din));

        // R2: asynchronous reset mid-operation.
        scan(1'b1, 3, 64'd7, dout);
        step(1'b1); step(1'b0); step(1'b0);
        #3 rst_n = 1'b0;
        #1;
        check("R3 oe low during async reset", {63'd0, tdo_oe}, 64'd0);
        check("R10 ring_out cleared by async reset", {58'd0, ring_out}, 64'd0);
        #10 rst_n = 1'b1;
        step(1'b0);
        scan(1'b0, DR_N, din, dout);
        check("R2 R4 async reset restores ident", dout[DR_N-1:0],
              expect_out(32, {32'd0, ID_VAL}, din));

        // R6, R7: shift 111, pause, resume; the earlier bits reappear at tdo.
        step(1'b1); step(1'b1); step(1'b0);
        tick(1'b0, 1'b0, so, oe);
        for (int i = 0; i < 3; i++) tick(i == 2, 1'b1, so, oe);
        tick(1'b0, 1'b0, so, oe);
        tick(1'b1, 1'b0, so, oe);
        check("R3 oe low in pause", {63'd0, oe}, 64'd0);
        tick(1'b0, 1'b0, so, oe);
        dout = '0;
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, (i == 0), so, oe);
            dout[i] = so;
        end
        check("R7 paused IR contents shift out", dout[2:0], 64'd7);
        step(1'b1); step(1'b0);
        scan(1'b0, DR_N, din, dout);
        check("R6 last updated code is active", dout[DR_N-1:0],
              expect_out(32, {32'd0, ID_VAL}, din));

        check("R1 tdo steady across rising edges", r1_bad, 0);
        check("R3 oe only in shift states", r3_bad, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule